// File: doc/BRIEF.md
# Selective Symbol Stream Descrambler

This block sits on the receive path of a serial link after the symbol decoder. It accepts one decoded 8-bit symbol per clock, each with a flag that marks it as a control (K) or data (D) symbol, and removes the transmitter's scrambling. A 16-bit linear feedback shift register with polynomial x^16 + x^5 + x^4 + x^3 + 1 runs in step with the far end. It advances eight times for every symbol it consumes, and its output bits are XORed into data symbols only.

The register follows the stream's own events. A comma symbol reloads it with all ones. A skip symbol leaves it frozen. Every other symbol moves it forward by one byte of keystream. Training ordered sets are sent unscrambled, so their bytes bypass the XOR while the register keeps advancing. A global enable input turns descrambling off for raw capture without losing step. Each symbol appears at the output, together with its control flag and a valid strobe, exactly one clock after it was presented.

Top module: `sym_descrambler`

## Requirements
- R1: Each valid input symbol appears on the outputs one clock later with out_valid_o high and out_ctrl_o equal to its control flag. An invalid input cycle gives out_valid_o low one clock later.
- R2: Control symbols (ctrl flag 1) pass out with their byte unchanged.
- R3: A data symbol is XORed with the keystream byte taken from the current register state. Keystream bit i (i = 0 first) is state bit 15. The state then shifts left by one, and when the bit shifted out is 1 it is XORed with 16'h0039. This is repeated eight times per symbol.
- R4: The comma symbol (ctrl 1, byte 8'hBC) loads the register with 16'hFFFF instead of advancing it.
- R5: The skip symbol (ctrl 1, byte 8'h1C) leaves the register unchanged.
- R6: Any other control symbol advances the register by eight steps, the same as a data symbol.
- R7: When the first symbol after a comma is data 8'h4A or 8'h45, that symbol and the next 14 valid symbols are training-set bytes. They leave unchanged while the register still advances for each one. Any other first symbol after a comma gives no bypass.
- R8: With en_i low, data symbols leave unchanged while the register still follows R3 to R6.
- R9: Cycles with in_valid_i low leave the register unchanged.
- R10: After reset the outputs are zero and the register holds 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Descrambling enable; low gives raw data |
| in_valid_i | input | 1 | Input symbol present |
| in_ctrl_i | input | 1 | Input symbol is a control symbol |
| in_data_i | input | 8 | Input symbol byte |
| out_valid_o | output | 1 | Output symbol present |
| out_ctrl_o | output | 1 | Output control flag |
| out_data_o | output | 8 | Descrambled symbol byte |

## Verification
The assertions assume that in_valid_i is low while reset is held, and that en_i changes only between symbols. The bench drives every input on the falling edge and keeps in_valid_i low throughout reset. The stimulus sweeps all 256 data byte values with descrambling on and with it off. It places commas, skips and other control symbols between data runs, and it sends both training set types, a comma followed by ordinary data, and idle gaps of varying length.

// File: rtl/descr_pkg.sv
package descr_pkg;
  localparam int          SYM_W      = 8;
  localparam int          LFSR_W     = 16;
  localparam logic [15:0] LFSR_TAPS  = 16'h0039;
  localparam logic [15:0] LFSR_SEED  = 16'hFFFF;
  localparam logic [7:0]  SYM_COMMA  = 8'hBC;
  localparam logic [7:0]  SYM_SKIP   = 8'h1C;
  localparam logic [7:0]  TRAIN_ID_A = 8'h4A;
  localparam logic [7:0]  TRAIN_ID_B = 8'h45;
  localparam int          TRAIN_LEN  = 16;

  typedef enum logic [1:0] {
    SYM_KIND_DATA,
    SYM_KIND_COMMA,
    SYM_KIND_SKIP,
    SYM_KIND_CTRL
  } sym_kind_e;
endpackage

// File: rtl/descr_lfsr.sv
module descr_lfsr #(
  parameter int          W     = 16,
  parameter int          STEPS = 8,
  parameter logic [W-1:0] TAPS = 16'h0039,
  parameter logic [W-1:0] SEED = 16'hFFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             load_i,
  output logic [W-1:0]     state_o,
  output logic [STEPS-1:0] key_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] chain [STEPS+1];

  assign chain[0] = state_q;

  for (genvar i = 0; i < STEPS; i++) begin : g_step
    assign key_o[i]   = chain[i][W-1];
    assign chain[i+1] = {chain[i][W-2:0], 1'b0} ^ (chain[i][W-1] ? TAPS : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (load_i) state_q <= SEED;
    else if (adv_i)  state_q <= chain[STEPS];
  end

  assign state_o = state_q;
endmodule

// File: rtl/descr_ts_track.sv
module descr_ts_track #(
  parameter int         SYM_W = 8,
  parameter int         LEN   = 16,
  parameter logic [SYM_W-1:0] ID_A = 8'h4A,
  parameter logic [SYM_W-1:0] ID_B = 8'h45
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             ctrl_i,
  input  logic [SYM_W-1:0] data_i,
  input  logic             comma_i,
  output logic             bypass_o
);
  localparam int CW = $clog2(LEN);

  logic          after_comma_q;
  logic [CW-1:0] left_q;
  logic          id_hit;

  assign id_hit   = after_comma_q && !ctrl_i && (data_i == ID_A || data_i == ID_B);
  assign bypass_o = valid_i && (id_hit || left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      after_comma_q <= 1'b0;
      left_q        <= '0;
    end else if (valid_i) begin
      if (comma_i) begin
        after_comma_q <= 1'b1;
        left_q        <= '0;
      end else begin
        after_comma_q <= 1'b0;
        if (id_hit)             left_q <= CW'(LEN - 2);
        else if (left_q != '0)  left_q <= left_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/sym_descrambler.sv
module sym_descrambler
  import descr_pkg::*;
#(
  parameter int          DW        = SYM_W,
  parameter int          LW        = LFSR_W,
  parameter logic [LW-1:0] TAPS    = LFSR_TAPS,
  parameter logic [LW-1:0] SEED    = LFSR_SEED,
  parameter logic [DW-1:0] COMMA   = SYM_COMMA,
  parameter logic [DW-1:0] SKIP    = SYM_SKIP,
  parameter int          OS_LEN    = TRAIN_LEN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          in_valid_i,
  input  logic          in_ctrl_i,
  input  logic [DW-1:0] in_data_i,
  output logic          out_valid_o,
  output logic          out_ctrl_o,
  output logic [DW-1:0] out_data_o
);
  sym_kind_e     kind;
  logic [LW-1:0] lfsr_q;
  logic [DW-1:0] key;
  logic          bypass;
  logic          do_xor;

  always_comb begin
    if (!in_ctrl_i)              kind = SYM_KIND_DATA;
    else if (in_data_i == COMMA) kind = SYM_KIND_COMMA;
    else if (in_data_i == SKIP)  kind = SYM_KIND_SKIP;
    else                         kind = SYM_KIND_CTRL;
  end

  descr_lfsr #(.W(LW), .STEPS(DW), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (in_valid_i && (kind == SYM_KIND_DATA || kind == SYM_KIND_CTRL)),
    .load_i  (in_valid_i && kind == SYM_KIND_COMMA),
    .state_o (lfsr_q),
    .key_o   (key)
  );

  descr_ts_track #(.SYM_W(DW), .LEN(OS_LEN), .ID_A(TRAIN_ID_A), .ID_B(TRAIN_ID_B)) u_ts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (in_valid_i),
    .ctrl_i   (in_ctrl_i),
    .data_i   (in_data_i),
    .comma_i  (kind == SYM_KIND_COMMA),
    .bypass_o (bypass)
  );

  assign do_xor = en_i && kind == SYM_KIND_DATA && !bypass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_ctrl_o  <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        out_ctrl_o <= in_ctrl_i;
        out_data_o <= do_xor ? (in_data_i ^ key) : in_data_i;
      end
    end
  end
endmodule

// File: rtl/descr_chk.sv
module descr_chk
  import descr_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        in_valid_i,
  input logic        in_ctrl_i,
  input logic [7:0]  in_data_i,
  input logic        out_valid_o,
  input logic        out_ctrl_o,
  input logic [7:0]  out_data_o,
  input logic [15:0] lfsr_q
);
  logic run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> out_valid_o == $past(in_valid_i)); // R1
  AST_CTRL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && $past(in_valid_i) |-> out_ctrl_o == $past(in_ctrl_i)); // R1
  AST_CTRL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && $past(in_valid_i && in_ctrl_i) |-> out_data_o == $past(in_data_i)); // R2
  AST_COMMA_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ctrl_i && in_data_i == SYM_COMMA |=> lfsr_q == LFSR_SEED); // R4
  AST_SKIP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ctrl_i && in_data_i == SYM_SKIP |=> $stable(lfsr_q)); // R5
  AST_RAW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && $past(in_valid_i && !in_ctrl_i && !en_i) |-> out_data_o == $past(in_data_i)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(lfsr_q)); // R9
  AST_IDLE_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_data_o) && $stable(out_ctrl_o)); // R9
endmodule

bind sym_descrambler descr_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .in_valid_i  (in_valid_i),
  .in_ctrl_i   (in_ctrl_i),
  .in_data_i   (in_data_i),
  .out_valid_o (out_valid_o),
  .out_ctrl_o  (out_ctrl_o),
  .out_data_o  (out_data_o),
  .lfsr_q      (lfsr_q)
);

// File: tb/sim_sym_descrambler.sv
module sim_sym_descrambler;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b1;
  logic       in_valid_i = 1'b0;
  logic       in_ctrl_i = 1'b0;
  logic [7:0] in_data_i = 8'h00;
  logic       out_valid_o;
  logic       out_ctrl_o;
  logic [7:0] out_data_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  // reference state
  logic [15:0] m_state = 16'hFFFF;
  logic        m_after = 1'b0;
  int          m_left = 0;
  // pending expectation
  logic        e_pend = 1'b0;
  logic        e_v = 1'b0, e_c = 1'b0;
  logic [7:0]  e_d = 8'h00;
  string       e_req = "";

  sym_descrambler u0 (.*);

  always #5 clk_i = ~clk_i;

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
      report();
    end
  end

  function automatic logic [7:0] key_of(logic [15:0] s);
    logic [7:0] k;
    for (int i = 0; i < 8; i++) begin
      k[i] = s[15];
      s = s[15] ? ((s << 1) ^ 16'h0039) : (s << 1);
    end
    return k;
  endfunction

  function automatic logic [15:0] adv_of(logic [15:0] s);
    for (int i = 0; i < 8; i++) s = s[15] ? ((s << 1) ^ 16'h0039) : (s << 1);
    return s;
  endfunction

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: check previous symbol's output, then drive next
  task automatic step(logic v, logic c, logic [7:0] d, string req);
    logic byp;
    @(negedge clk_i);
    if (e_pend) begin
      check({e_req, "/R1 valid"}, {8'h00, out_valid_o}, {8'h00, e_v});
      if (e_v) check(e_req, {out_ctrl_o, out_data_o}, {e_c, e_d});
    end
    e_pend = 1'b1; e_v = v; e_req = req;
    if (v) begin
      byp = 1'b0;
      e_c = c;
      if (c && d == 8'hBC) begin
        e_d = d; m_state = 16'hFFFF; m_after = 1'b1; m_left = 0;
      end else begin
        if (m_after && !c && (d == 8'h4A || d == 8'h45)) begin
          byp = 1'b1; m_left = 14;
        end else if (m_left > 0) begin
          byp = 1'b1; m_left--;
        end
        m_after = 1'b0;
        e_d = (!c && en_i && !byp) ? (d ^ key_of(m_state)) : d;
        if (!(c && d == 8'h1C)) m_state = adv_of(m_state);
      end
    end
    in_valid_i = v; in_ctrl_i = c; in_data_i = d;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 reset outputs", {out_valid_o, out_data_o}, 9'h000);
    check("R10 reset ctrl", {8'h00, out_ctrl_o}, 9'h000);
    rst_ni = 1'b1;

    // first data after reset uses seed keystream
    step(1, 0, 8'h00, "R10 seed keystream");
    // full data sweep, descrambling on
    for (int b = 0; b < 256; b++) step(1, 0, 8'(b), "R3 data sweep");
    // comma reseeds, then data
    step(1, 1, 8'hBC, "R2 comma pass");
    step(1, 0, 8'h00, "R4 data after comma");
    for (int b = 0; b < 20; b++) step(1, 0, 8'(b * 13), "R4 run after comma");
    // skips do not advance
    for (int r = 1; r < 4; r++) begin
      for (int k = 0; k < r; k++) step(1, 1, 8'h1C, "R5 skip");
      for (int b = 0; b < 5; b++) step(1, 0, 8'(b + r), "R5 data after skip");
    end
    // other control symbols advance
    step(1, 1, 8'hFB, "R6 ctrl pass");
    step(1, 0, 8'h55, "R6 data after ctrl");
    step(1, 1, 8'hFD, "R6 ctrl pass");
    step(1, 1, 8'hF7, "R6 ctrl pass");
    step(1, 0, 8'hAA, "R6 data after ctrl");
    // training sets of both kinds
    for (int t = 0; t < 2; t++) begin
      step(1, 1, 8'hBC, "R7 set comma");
      step(1, 0, t == 0 ? 8'h4A : 8'h45, "R7 set id");
      for (int k = 0; k < 14; k++) step(1, 0, 8'(k * 7 + t), "R7 set body");
      for (int k = 0; k < 6; k++) step(1, 0, 8'(k), "R7 after set");
    end
    // comma followed by ordinary data: no bypass
    step(1, 1, 8'hBC, "R7 comma");
    step(1, 0, 8'h4B, "R7 non-id");
    for (int k = 0; k < 4; k++) step(1, 0, 8'h4A, "R7 late id");
    // idle gaps hold state
    for (int g = 1; g < 6; g++) begin
      for (int k = 0; k < g; k++) step(0, 0, 8'hFF, "R9 idle");
      step(1, 0, 8'h3C, "R9 data after idle");
    end
    // descrambling off: raw data, register keeps step
    @(negedge clk_i);
    check({e_req, "/R1 valid"}, {8'h00, out_valid_o}, {8'h00, e_v});
    if (e_v) check(e_req, {out_ctrl_o, out_data_o}, {e_c, e_d});
    e_pend = 1'b0;
    in_valid_i = 1'b0;
    en_i = 1'b0;
    for (int b = 0; b < 256; b++) step(1, 0, 8'(b), "R8 raw sweep");
    step(1, 1, 8'h1C, "R8 skip while off");
    en_i = 1'b0;
    step(1, 0, 8'h11, "R8 raw");
    @(negedge clk_i);
    check({e_req, "/R1 valid"}, {8'h00, out_valid_o}, {8'h00, e_v});
    check(e_req, {out_ctrl_o, out_data_o}, {e_c, e_d});
    e_pend = 1'b0;
    in_valid_i = 1'b0;
    en_i = 1'b1;
    // register stayed in step while off
    for (int b = 0; b < 16; b++) step(1, 0, 8'(b * 17), "R8 resume in step");
    step(0, 0, 8'h00, "R1 final idle");
    step(0, 0, 8'h00, "R1 final idle");
    report();
  end
endmodule